// File: doc/BRIEF.md
# Conditional-Branch Microsequencer

This block is the address-sequencing half of a microprogrammed control unit. A control address register points into a writable control store of 64 microinstructions, each 26 bits wide. The store is read without a clock, so the 16 processor-control bits of the current microinstruction reach the datapath in the same cycle that the address is held.

Each microinstruction also carries three fields that choose the next address. A 3-bit condition select picks one of eight branch conditions. These are two constants, the carry flag and its inverse, the zero flag and its inverse, the sign flag, and the overflow flag. When the chosen condition is true, the register loads a branch target. A 1-bit source field decides whether that target is the microinstruction's own 6-bit next-address field or an address from outside, such as an opcode map. When the condition is false, the register moves to the following address.

The status flags are expected to come from flops in the datapath. A separate write port fills the control store before or during operation.

Top module: `useq_seq`

## Requirements
- R1: While `rst_ni` is low the address output is 0, and reset takes effect without a clock edge.
- R2: `ctrl_o` always equals bits [15:0] of the store entry addressed by `addr_o`.
- R3: With condition select 0 (constant false), the address advances by one at the next clock edge.
- R4: With condition select 1 (constant true), the address always loads the branch target at the next clock edge.
- R5: Select 2 branches when `flag_c_i` is 1, and select 3 branches when `flag_c_i` is 0. Otherwise the address advances by one.
- R6: Select 4 branches when `flag_z_i` is 1, and select 5 branches when `flag_z_i` is 0. Otherwise the address advances by one.
- R7: Select 6 branches when `flag_s_i` is 1, and select 7 branches when `flag_v_i` is 1. Otherwise the address advances by one.
- R8: The branch target is bits [25:20] of the entry when bit 16 is 0, and `ext_addr_i` when bit 16 is 1. The condition select sits in bits [19:17].
- R9: An advance from address 63 wraps to address 0.
- R10: A write with `wr_en_i` high updates the addressed entry at the clock edge. A cycle with `wr_en_i` low leaves the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control store write enable |
| wr_addr_i | input | 6 | Control store write address |
| wr_data_i | input | 26 | Microinstruction to write |
| ext_addr_i | input | 6 | External branch target |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| flag_s_i | input | 1 | Sign flag |
| flag_v_i | input | 1 | Overflow flag |
| ctrl_o | output | 16 | Processor-control bits of the current microinstruction |
| addr_o | output | 6 | Current control address |

## Verification
The main run fills every store entry so that all eight condition selects and both target sources occur. It then steps the sequencer for several hundred cycles while a pseudo-random pattern drives the four flags and the external address. Because the flags change independently, each test tells the correct flag and polarity apart from a wrong one, and tells a branch apart from an advance by one. Directed steps force a branch to address 63 through the external source and an advance from there, which shows the wrap to 0. Writes made while the store is held in reset separate enabled writes from disabled ones by their effect on `ctrl_o`.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CTRL_W = 16;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = 6;
  localparam int WORD_W = ADDR_W + SEL_W + 1 + CTRL_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [SEL_W-1:0] {
    COND_ZERO  = 3'd0,
    COND_ONE   = 3'd1,
    COND_C     = 3'd2,
    COND_NC    = 3'd3,
    COND_Z     = 3'd4,
    COND_NZ    = 3'd5,
    COND_S     = 3'd6,
    COND_V     = 3'd7
  } cond_sel_e;

  // Packed MSB first: target [25:20], select [19:17], source [16], control [15:0]
  typedef struct packed {
    logic [ADDR_W-1:0] nxt;
    logic [SEL_W-1:0]  sel;
    logic              src;
    logic [CTRL_W-1:0] ctrl;
  } uinst_t;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 6,
  parameter int DW = 26
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int N = 1 << AW;

  logic [DW-1:0] mem_q [N];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic [SW-1:0] sel_i,
  input  logic          flag_c_i,
  input  logic          flag_z_i,
  input  logic          flag_s_i,
  input  logic          flag_v_i,
  output logic          taken_o
);
  localparam int N = 1 << SW;

  logic [N-1:0] cond_vec;

  always_comb begin
    cond_vec          = '0;
    cond_vec[COND_ONE] = 1'b1;
    cond_vec[COND_C]   = flag_c_i;
    cond_vec[COND_NC]  = ~flag_c_i;
    cond_vec[COND_Z]   = flag_z_i;
    cond_vec[COND_NZ]  = ~flag_z_i;
    cond_vec[COND_S]   = flag_s_i;
    cond_vec[COND_V]   = flag_v_i;
  end

  assign taken_o = cond_vec[sel_i];
endmodule

// File: rtl/useq_car.sv
module useq_car #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          taken_i,
  input  logic          src_i,
  input  logic [AW-1:0] nxt_i,
  input  logic [AW-1:0] ext_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] addr_q, addr_d, tgt;

  assign tgt    = src_i ? ext_i : nxt_i;
  assign addr_d = taken_i ? tgt : addr_q + ONE;  // natural wrap at the top

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/useq_seq.sv
module useq_seq
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              flag_c_i,
  input  logic              flag_z_i,
  input  logic              flag_s_i,
  input  logic              flag_v_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [WORD_W-1:0] rd_word;
  uinst_t            uinst;
  logic              taken;
  logic [ADDR_W-1:0] car_addr;

  useq_store #(.AW(ADDR_W), .DW(WORD_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_en_i),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (car_addr),
    .rdata_o (rd_word)
  );

  assign uinst = uinst_t'(rd_word);

  useq_cond #(.SW(SEL_W)) u_cond (
    .sel_i    (uinst.sel),
    .flag_c_i (flag_c_i),
    .flag_z_i (flag_z_i),
    .flag_s_i (flag_s_i),
    .flag_v_i (flag_v_i),
    .taken_o  (taken)
  );

  useq_car #(.AW(ADDR_W)) u_car (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .taken_i (taken),
    .src_i   (uinst.src),
    .nxt_i   (uinst.nxt),
    .ext_i   (ext_addr_i),
    .addr_o  (car_addr)
  );

  assign addr_o = car_addr;
  assign ctrl_o = uinst.ctrl;
endmodule

// File: rtl/useq_seq_chk.sv
module useq_seq_chk
  import useq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic [SEL_W-1:0]  sel_i,
  input logic              src_i,
  input logic [ADDR_W-1:0] nxt_i,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic              flag_c_i,
  input logic              flag_z_i,
  input logic              flag_s_i,
  input logic              flag_v_i
);
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [ADDR_W-1:0] tgt;
  assign tgt = src_i ? ext_addr_i : nxt_i;

  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> addr_o == '0);

  p_never_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == COND_ZERO |=> addr_o == $past(addr_o) + ONE);

  p_always_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == COND_ONE |=> addr_o == $past(tgt));

  p_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == COND_C && !flag_c_i) || (sel_i == COND_NC && flag_c_i)
    |=> addr_o == $past(addr_o) + ONE);

  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == COND_Z && flag_z_i) || (sel_i == COND_NZ && !flag_z_i)
    |=> addr_o == $past(tgt));

  p_sign_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == COND_S && flag_s_i) || (sel_i == COND_V && flag_v_i)
    |=> addr_o == $past(tgt));

  p_ext_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == COND_ONE && src_i |=> addr_o == $past(ext_addr_i));

  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == COND_ZERO && addr_o == LAST |=> addr_o == '0);
endmodule

bind useq_seq useq_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_o     (addr_o),
  .sel_i      (uinst.sel),
  .src_i      (uinst.src),
  .nxt_i      (uinst.nxt),
  .ext_addr_i (ext_addr_i),
  .flag_c_i   (flag_c_i),
  .flag_z_i   (flag_z_i),
  .flag_s_i   (flag_s_i),
  .flag_v_i   (flag_v_i)
);

// File: tb/useq_seq_bench.sv
module useq_seq_bench;
  import useq_pkg::*;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [WORD_W-1:0] wr_data_i = '0;
  logic [ADDR_W-1:0] ext_addr_i = '0;
  logic              flag_c_i = 1'b0, flag_z_i = 1'b0, flag_s_i = 1'b0, flag_v_i = 1'b0;
  logic [CTRL_W-1:0] ctrl_o;
  logic [ADDR_W-1:0] addr_o;

  always #4 clk_i = ~clk_i;

  useq_seq u_useq_seq (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .ext_addr_i,
    .flag_c_i, .flag_z_i, .flag_s_i, .flag_v_i, .ctrl_o, .addr_o
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [CTRL_W-1:0] ctrl;
    int                req;
  } exp_t;

  logic [WORD_W-1:0] model [DEPTH];
  exp_t              q [$];
  logic [ADDR_W-1:0] cur;
  logic [15:0]       lfsr = 16'hACE1;
  int                n_chk = 0, n_fail = 0;

  function automatic string tag(int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, int r, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag(r), act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] mk(int i);
    logic [ADDR_W-1:0] n;
    logic [SEL_W-1:0]  s;
    logic [CTRL_W-1:0] c;
    n = ADDR_W'((i * 7 + 3) % DEPTH);
    s = SEL_W'(i % 8);
    c = CTRL_W'(i * 257) ^ 16'hA5C3;
    return {n, s, (i % 5 == 0), c};
  endfunction

  // Condition table as stated in R3..R7
  function automatic bit cond(logic [2:0] s);
    case (s)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return flag_c_i;
      3'd3: return !flag_c_i;
      3'd4: return flag_z_i;
      3'd5: return !flag_z_i;
      3'd6: return flag_s_i;
      default: return flag_v_i;
    endcase
  endfunction

  function automatic int sel_req(logic [2:0] s);
    case (s)
      3'd0: return 3;  3'd1: return 4;
      3'd2, 3'd3: return 5;
      3'd4, 3'd5: return 6;
      default: return 7;
    endcase
  endfunction

  // Driver: inputs already set; predict the address after the next edge
  task automatic step();
    logic [WORD_W-1:0] w;
    logic [ADDR_W-1:0] nx;
    int                r;
    exp_t              e;
    @(posedge clk_i);
    w = model[cur];
    if (cond(w[19:17])) begin
      nx = w[16] ? ext_addr_i : w[25:20];
      r  = w[16] ? 8 : sel_req(w[19:17]);
    end else begin
      nx = cur + ADDR_W'(1);
      r  = (cur == '1) ? 9 : sel_req(w[19:17]);
    end
    if (wr_en_i) model[wr_addr_i] = wr_data_i;
    cur    = nx;
    e.addr = nx;
    e.ctrl = model[nx][15:0];
    e.req  = r;
    q.push_back(e);
    #2;
  endtask

  // Monitor
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(addr_o == e.addr, e.req, int'(addr_o), int'(e.addr));
      check(ctrl_o == e.ctrl, 2, int'(ctrl_o), int'(e.ctrl));
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    @(posedge clk_i); #2;
    for (int i = 0; i < DEPTH; i++) begin
      wr_en_i = 1'b1; wr_addr_i = ADDR_W'(i); wr_data_i = mk(i);
      model[i] = mk(i);
      @(posedge clk_i); #2;
    end
    wr_en_i = 1'b0;
    @(negedge clk_i);
    check(addr_o == '0, 1, int'(addr_o), 0);                        // R1
    check(ctrl_o == model[0][15:0], 2, int'(ctrl_o), int'(model[0][15:0])); // R2
    rst_ni = 1'b1;
    cur = '0;

    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      {flag_c_i, flag_z_i, flag_s_i, flag_v_i} = lfsr[3:0];
      ext_addr_i = lfsr[13:8];
      wr_en_i    = (k % 16 == 5);
      wr_addr_i  = lfsr[9:4];
      wr_data_i  = mk(int'(lfsr[15:8]));
      step();
    end
    wr_en_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);

    // R10 while held in reset at address 0
    rst_ni = 1'b0;
    #1 check(addr_o == '0, 1, int'(addr_o), 0);                     // R1 async
    wr_addr_i = '0; wr_data_i = {6'd0, 3'd1, 1'b1, 16'hBEEF}; wr_en_i = 1'b0;
    @(posedge clk_i); #2;
    @(negedge clk_i);
    check(ctrl_o == model[0][15:0], 10, int'(ctrl_o), int'(model[0][15:0]));
    wr_en_i = 1'b1;
    @(posedge clk_i);
    model[0] = wr_data_i;
    #2 wr_en_i = 1'b0;
    @(negedge clk_i);
    check(ctrl_o == 16'hBEEF, 10, int'(ctrl_o), 16'hBEEF);
    wr_en_i = 1'b1; wr_addr_i = '1; wr_data_i = {6'd9, 3'd0, 1'b0, 16'h6363};
    @(posedge clk_i);
    model[DEPTH-1] = wr_data_i;
    #2 wr_en_i = 1'b0;

    // R8 external jump to 63, then R9 wrap to 0
    ext_addr_i = '1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    cur = '0;
    step();
    step();
    @(negedge clk_i); @(negedge clk_i);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule